// File: doc/BRIEF.md
# Masked Data Breakpoint Matcher

This block holds a small set of data-address watch entries and compares every memory access request against them. Each entry has a base address register and a control register. The control register carries a load enable, a store enable and a low-order mask field. When an access request is presented, the block raises a hit flag in the same cycle, before the memory is touched, so the surrounding pipeline can suppress the access. It also reports the index of the entry that matched.

Every entry compares a naturally aligned region of addresses rather than a single word. The width of that region comes from the mask field. A mask field that is not a single run of ones is trimmed so that only its top run survives, which means the compared region always has a power-of-two size. Configuration goes through one write port that selects an entry and one of its two registers. The internal comparison state is re-armed only when a write changes something that affects matching.

Top module: `dbk_matcher`

## Requirements
- R1: After reset every entry is disabled and `hit` stays low for any access.
- R2: Control word layout: bits 5:0 form the mask field, bit 30 is the load enable and bit 31 is the store enable; the other control bits have no effect. A mask field bit of 1 means the corresponding address bit is compared, and address bits 31:6 are always compared.
- R3: A read (`acc_write`=0) can match an entry only when that entry's load enable is set. A write (`acc_write`=1) can match only when its store enable is set.
- R4: An entry matches when the access address and the base address are equal on every bit where the effective mask is 1. The effective mask is all ones above the field, with the field in the low bits. The matched region spans (inverted mask + 1) bytes, aligned to that size.
- R5: A mask field that is not contiguous is cut below its first zero bit, counting down from bit 31. For example, field 0x3A acts as 0x38.
- R6: An entry with both enables clear never matches, whatever its address and mask.
- R7: `hit` and `hit_idx` are combinational from the access inputs in the same cycle, and `hit` is low whenever `acc_valid` is low.
- R8: When several entries match, `hit_idx` reports the lowest matching index.
- R9: A configuration write takes effect from the next clock cycle. A control write that changes only bits outside the enables and the mask field changes nothing. A base address written while the entry is disabled is kept and is used once the entry is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | IW | Entry selected by the write |
| cfg_kind | input | 1 | Register selected: 0 base address, 1 control |
| cfg_wdata | input | 32 | Write data |
| acc_valid | input | 1 | Access request present |
| acc_write | input | 1 | 1 for a store, 0 for a load |
| acc_addr | input | 32 | Access address |
| hit | output | 1 | Some entry matches the current access |
| hit_idx | output | IW | Index of the lowest matching entry |

## Verification
Loads and stores are each aimed at entries that have only one enable set, which separates the two eligibility paths. Addresses are placed just inside and just outside the region edges for several contiguous fields, and a field of zero gives the widest region. A non-contiguous field is probed at an address that matches only when the field has been trimmed, which separates the trimming from a raw bitwise compare. Two entries are set over the same address to expose the priority order. Writes to bits outside the enables and the mask, and base writes made while an entry is disabled, show whether re-arming is gated correctly. A randomized sweep is then checked against an independent model.

// File: rtl/dbk_pkg.sv
package dbk_pkg;
  localparam int DW     = 32;
  localparam int LD_POS = 30;
  localparam int ST_POS = 31;

  typedef enum logic {REG_ADDR = 1'b0, REG_CTRL = 1'b1} reg_kind_e;

  // Ones above the field, field bits as written below it.
  function automatic logic [DW-1:0] raw_mask(input logic [DW-1:0] ctrl, input int fw);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) r[i] = (i < fw) ? ctrl[i] : 1'b1;
    return r;
  endfunction

  // Keep only the run of ones starting at the top bit.
  function automatic logic [DW-1:0] trim_mask(input logic [DW-1:0] m);
    logic [DW-1:0] r;
    logic brk;
    r = '1;
    brk = 1'b0;
    for (int i = DW - 1; i >= 0; i--) begin
      if (!m[i]) brk = 1'b1;
      if (brk) r[i] = 1'b0;
    end
    return r;
  endfunction
endpackage

// File: rtl/dbk_slot.sv
module dbk_slot
  import dbk_pkg::*;
#(
  parameter int FIELD_W = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_addr,
  input  logic          wr_ctrl,
  input  logic [DW-1:0] wdata,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [DW-1:0] acc_addr,
  output logic          slot_hit,
  output logic          rearm,
  output logic [DW-1:0] arm_mask
);
  localparam int SENSE_W = FIELD_W + 2;

  logic [DW-1:0]      addr_q, ctrl_q, arm_base;
  logic               arm_ld, arm_st;
  logic [SENSE_W-1:0] sense_new, sense_old;
  logic               ctrl_chg, addr_chg;
  logic [DW-1:0]      new_mask;

  assign sense_new = {wdata[ST_POS], wdata[LD_POS], wdata[FIELD_W-1:0]};
  assign sense_old = {ctrl_q[ST_POS], ctrl_q[LD_POS], ctrl_q[FIELD_W-1:0]};
  assign ctrl_chg  = wr_ctrl && (sense_new != sense_old);
  assign addr_chg  = wr_addr && (wdata != addr_q) && (ctrl_q[ST_POS] || ctrl_q[LD_POS]);
  assign rearm     = ctrl_chg || addr_chg;
  assign new_mask  = trim_mask(raw_mask(wdata, FIELD_W));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      ctrl_q   <= '0;
      arm_base <= '0;
      arm_mask <= '1;
      arm_ld   <= 1'b0;
      arm_st   <= 1'b0;
    end else begin
      if (wr_addr) addr_q <= wdata;
      if (wr_ctrl) ctrl_q <= wdata;
      if (ctrl_chg) begin
        arm_mask <= new_mask;
        arm_base <= addr_q & new_mask;
        arm_ld   <= wdata[LD_POS];
        arm_st   <= wdata[ST_POS];
      end else if (addr_chg) begin
        arm_base <= wdata & arm_mask;
      end
    end
  end

  assign slot_hit = acc_valid && (acc_write ? arm_st : arm_ld) &&
                    ((acc_addr & arm_mask) == arm_base);
endmodule

// File: rtl/dbk_pick.sv
module dbk_pick #(
  parameter int N  = 2,
  parameter int IW = 1
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
  assign any = |vec;
endmodule

// File: rtl/dbk_matcher.sv
module dbk_matcher
  import dbk_pkg::*;
#(
  parameter int N_BP    = 2,
  parameter int FIELD_W = 6,
  parameter int IW      = (N_BP > 1) ? $clog2(N_BP) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_sel,
  input  logic          cfg_kind,
  input  logic [31:0]   cfg_wdata,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [31:0]   acc_addr,
  output logic          hit,
  output logic [IW-1:0] hit_idx
);
  logic [N_BP-1:0]    slot_hits;
  logic [N_BP-1:0]    rearm_vec;
  logic [N_BP*DW-1:0] arm_flat;

  for (genvar g = 0; g < N_BP; g++) begin : g_slot
    logic sel_me;
    assign sel_me = cfg_we && (cfg_sel == IW'(g));
    dbk_slot #(.FIELD_W(FIELD_W)) slot_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_addr   (sel_me && (cfg_kind == REG_ADDR)),
      .wr_ctrl   (sel_me && (cfg_kind == REG_CTRL)),
      .wdata     (cfg_wdata),
      .acc_valid (acc_valid),
      .acc_write (acc_write),
      .acc_addr  (acc_addr),
      .slot_hit  (slot_hits[g]),
      .rearm     (rearm_vec[g]),
      .arm_mask  (arm_flat[g*DW +: DW])
    );
  end

  dbk_pick #(.N(N_BP), .IW(IW)) pick_i (
    .vec (slot_hits),
    .any (hit),
    .idx (hit_idx)
  );
endmodule

// File: rtl/dbk_matcher_chk.sv
module dbk_matcher_chk #(
  parameter int N_BP = 2,
  parameter int IW   = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic             hit,
  input logic [IW-1:0]    hit_idx,
  input logic [N_BP-1:0]  slot_hits,
  input logic [N_BP-1:0]  rearm_vec,
  input logic [N_BP*32-1:0] arm_flat
);
  logic [N_BP-1:0] below;
  assign below = (N_BP'(1) << hit_idx) - N_BP'(1);

  a_r7_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> acc_valid);
  a_r7_hit_tracks_slots: assert property (@(posedge clk) disable iff (!rst_n)
    hit == (|slot_hits));
  a_r8_lowest_index: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (slot_hits[hit_idx] && ((slot_hits & below) == '0)));
  a_r9_hold_without_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm_vec == '0) |=> $stable(arm_flat));

  for (genvar g = 0; g < N_BP; g++) begin : g_contig
    logic [31:0] inv;
    assign inv = ~arm_flat[g*32 +: 32];
    a_r5_mask_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
      ((inv + 32'd1) & inv) == 32'd0);
  end
endmodule

bind dbk_matcher dbk_matcher_chk #(.N_BP(N_BP), .IW(IW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_valid (acc_valid),
  .hit       (hit),
  .hit_idx   (hit_idx),
  .slot_hits (slot_hits),
  .rearm_vec (rearm_vec),
  .arm_flat  (arm_flat)
);

// File: tb/dbk_matcher_tb_top.sv
module dbk_matcher_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 2;
  localparam int IWB = 1;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cfg_we = 1'b0;
  logic [IWB-1:0] cfg_sel = '0;
  logic           cfg_kind = 1'b0;
  logic [31:0]    cfg_wdata = '0;
  logic           acc_valid = 1'b0;
  logic           acc_write = 1'b0;
  logic [31:0]    acc_addr = '0;
  logic           hit;
  logic [IWB-1:0] hit_idx;

  int total = 0;
  int bad = 0;
  bit done = 0;

  bit    q_hit[$];
  int    q_idx[$];
  string q_tag[$];

  logic [31:0] m_addr[NB];
  logic [31:0] m_ctrl[NB];

  always #(CLK_PERIOD/2) clk = ~clk;

  dbk_matcher #(.N_BP(NB), .FIELD_W(6)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_kind(cfg_kind), .cfg_wdata(cfg_wdata), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_addr(acc_addr), .hit(hit), .hit_idx(hit_idx)
  );

  // Independent model: count leading ones of the field-extended mask.
  function automatic logic [31:0] model_mask(input logic [31:0] ctrl);
    logic [31:0] raw;
    int lead;
    raw = {26'h3ffffff, ctrl[5:0]};
    lead = 0;
    while (lead < 32 && raw[31-lead]) lead++;
    return (lead == 32) ? 32'hffffffff : (32'hffffffff << (32 - lead));
  endfunction

  function automatic int model_pick(input logic v, input logic w, input logic [31:0] a);
    for (int i = 0; i < NB; i++) begin
      logic [31:0] m;
      logic en;
      m = model_mask(m_ctrl[i]);
      en = w ? m_ctrl[i][31] : m_ctrl[i][30];
      if (v && en && ((a & m) == (m_addr[i] & m))) return i;
    end
    return -1;
  endfunction

  always @(negedge clk) begin
    if (q_hit.size() > 0) begin
      bit eh; int ei; string t;
      eh = q_hit.pop_front();
      ei = q_idx.pop_front();
      t  = q_tag.pop_front();
      total++;
      if (hit !== eh || (eh && int'(hit_idx) != ei)) begin
        bad++;
        $display("FAIL %s: hit=%0b idx=%0d expected hit=%0b idx=%0d", t, hit, hit_idx, eh, ei);
      end
    end
  end

  task automatic cfg(input int sel, input logic kind, input logic [31:0] d);
    @(posedge clk); #1;
    acc_valid = 0; cfg_we = 1; cfg_sel = IWB'(sel); cfg_kind = kind; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0;
    if (kind) m_ctrl[sel] = d; else m_addr[sel] = d;
  endtask

  task automatic probe(input logic v, input logic w, input logic [31:0] a,
                       input int exp_idx, input string tag);
    @(posedge clk); #1;
    acc_valid = v; acc_write = w; acc_addr = a;
    q_hit.push_back(exp_idx >= 0);
    q_idx.push_back(exp_idx);
    q_tag.push_back(tag);
    @(negedge clk); #1;
    acc_valid = 0;
  endtask

  task automatic probe_model(input logic v, input logic w, input logic [31:0] a, input string tag);
    probe(v, w, a, model_pick(v, w, a), tag);
  endtask

  localparam logic [31:0] LD = 32'h4000_0000;
  localparam logic [31:0] ST = 32'h8000_0000;

  initial begin
    for (int i = 0; i < NB; i++) begin m_addr[i] = 0; m_ctrl[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    probe(1, 0, 32'h0, -1, "R1 reset read");
    probe(1, 1, 32'h0, -1, "R1 reset write");

    cfg(0, 0, 32'h1000);
    cfg(0, 1, LD | 32'h3f);
    probe(1, 0, 32'h1000, 0, "R3 load enabled read");
    probe(1, 1, 32'h1000, -1, "R3 store not enabled");
    probe(1, 0, 32'h1001, -1, "R4 exact compare");
    probe(0, 0, 32'h1000, -1, "R7 no valid");
    probe(1, 0, 32'h81000, -1, "R2 upper bits compared");

    cfg(0, 1, LD | ST | 32'h3c);
    probe(1, 1, 32'h1003, 0, "R4 region top");
    probe(1, 0, 32'h1004, -1, "R4 past region");
    probe(1, 0, 32'h0fff, -1, "R4 below region");

    cfg(0, 1, ST | 32'h3a);
    probe(1, 1, 32'h1002, 0, "R5 trimmed field");
    probe(1, 1, 32'h1007, 0, "R5 trimmed top");
    probe(1, 1, 32'h1008, -1, "R5 outside");

    cfg(0, 1, ST | 32'h00);
    probe(1, 1, 32'h103f, 0, "R4 widest region");
    probe(1, 1, 32'h1040, -1, "R4 widest edge");

    cfg(0, 1, 32'h3f);
    probe(1, 0, 32'h1000, -1, "R6 disabled read");
    probe(1, 1, 32'h1000, -1, "R6 disabled write");

    cfg(1, 0, 32'h1000);
    cfg(0, 1, LD | 32'h3f);
    cfg(1, 1, LD | 32'h3f);
    probe(1, 0, 32'h1000, 0, "R8 lowest wins");
    cfg(0, 1, 32'h0);
    probe(1, 0, 32'h1000, 1, "R8 next entry");

    cfg(1, 1, LD | 32'h3f | 32'h0000_0400);
    probe(1, 0, 32'h1000, 1, "R2 R9 unrelated bit no effect");
    cfg(0, 0, 32'h2200);
    probe(1, 0, 32'h2200, -1, "R9 addr kept while disabled");
    cfg(0, 1, LD | 32'h3f);
    probe(1, 0, 32'h2200, 0, "R9 stored addr used on enable");
    cfg(1, 0, 32'h3300);
    probe(1, 0, 32'h3300, 1, "R9 addr rewrite while enabled");
    probe(1, 0, 32'h1000, -1, "R9 old addr gone");

    for (int k = 0; k < 300; k++) begin
      if (($urandom % 4) == 0) begin
        int s;
        s = $urandom % NB;
        if ($urandom % 2) cfg(s, 0, 32'h2000 | ($urandom % 256));
        else cfg(s, 1, ($urandom & 32'hc000_003f) | ($urandom & 32'h0000_0f00));
      end
      probe_model(($urandom % 8) != 0, $urandom % 2, 32'h2000 | ($urandom % 256), "R4 R8 sweep");
    end

    @(posedge clk); @(negedge clk); #1;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule